// File: doc/BRIEF.md
# Tag-Capture Reservation Station Pool

This block holds instructions that wait for one class of floating-point functional unit until their source operands are available. The in-order issue logic presents one instruction per cycle: an opcode, an immediate/address field, and for each of two sources either a ready value (tag zero) or the nonzero tag of the station that will produce it. If a station is free, the instruction goes into the lowest-numbered free one, and that station's tag is returned at once so the rename logic can record it as the new producer. If no station is free, a stall is raised and the instruction is not taken.

Every station watches a shared result bus that carries a producer tag and a value. Any waiting operand whose tag matches takes the value in the same edge. This includes the operands of an instruction that is being issued in that cycle. A station whose two operands are both present is offered to the functional unit, and the lowest-numbered ready station goes first. A station stays occupied while its operation executes. It becomes free when its own tag appears on the result bus.

Top module: `rs_pool`

## Requirements
- R1: After reset every station is free, `iss_stall` is low, `fu_valid` is low and `iss_tag` shows tag 1.
- R2: When `iss_stall` is low, `iss_tag` shows the tag of the lowest-numbered free station in the same cycle. Station k (counting from 0) has tag `TAG_BASE`+k, and `TAG_BASE` defaults to 1. An instruction issued with `iss_valid` goes into that station.
- R3: `iss_stall` is high exactly when every station is occupied. An instruction presented while the stall is high is dropped and never reaches the functional unit.
- R4: A source tag of 0 means the value supplied with it is used. A nonzero tag makes the operand wait, and the value supplied with it is ignored.
- R5: A result bus transfer (`cdb_valid` high) fills every waiting operand in every station whose tag equals `cdb_tag`, all at one edge.
- R6: If a result is broadcast in the same cycle as an issue whose source tag matches it, the new station captures the broadcast value for that source.
- R7: A station is offered on `fu_valid` only when both of its operands hold values, starting the cycle after the last one arrives. `fu_op`, `fu_a` and `fu_b` then carry its opcode and operand values, and `fu_tag` carries its tag.
- R8: When several stations are ready, the lowest-numbered one is offered first. One is offered per cycle, and each instruction is offered exactly once.
- R9: A station becomes free at the edge where its own tag is broadcast. The stall drops and the station can be allocated from the next cycle onward. The stall stays high in the broadcast cycle itself.
- R10: `fu_imm` carries the immediate/address field that was issued with the instruction being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_op | input | OP_W | Opcode of the issued instruction |
| iss_imm | input | IMM_W | Immediate / address field |
| iss_src1_tag | input | TAG_W | Producer tag of source 1, 0 when the value is ready |
| iss_src1_val | input | DATA_W | Value of source 1 |
| iss_src2_tag | input | TAG_W | Producer tag of source 2, 0 when the value is ready |
| iss_src2_val | input | DATA_W | Value of source 2 |
| iss_stall | output | 1 | No free station; the issue is not accepted |
| iss_tag | output | TAG_W | Tag of the station that would take the instruction |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Tag of the producing station |
| cdb_value | input | DATA_W | Result value |
| fu_valid | output | 1 | A ready instruction is handed to the functional unit |
| fu_tag | output | TAG_W | Tag of the station being dispatched |
| fu_op | output | OP_W | Opcode of the dispatched instruction |
| fu_a | output | DATA_W | First operand value |
| fu_b | output | DATA_W | Second operand value |
| fu_imm | output | IMM_W | Immediate / address field of the dispatched instruction |

## Verification
`iss_stall` and `iss_tag` depend only on the registered state, so their value for a given cycle is already settled before that cycle's edge. A capture, an allocation and a release each show up one edge later. A station whose last operand arrives at edge N is offered from just after edge N and is dispatched at edge N+1. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. It runs the dispatch order one cycle at a time, so every result is read in the cycle it is due.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;

    // Life cycle of one station
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,   // empty, may be allocated
        ST_WAIT = 2'd1,   // holds an instruction, waiting for operands or dispatch
        ST_EXEC = 2'd2    // handed to the functional unit, waiting for own broadcast
    } rs_state_e;

endpackage

// File: rtl/rs_lowest_pick.sv
// Fixed-priority picker: lowest index of a request vector wins.
module rs_lowest_pick #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rs_operand_capture.sv
// Next value of one operand slot given a result bus transfer.
module rs_operand_capture #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [DATA_W-1:0] cur_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic [TAG_W-1:0]  nxt_tag,
    output logic [DATA_W-1:0] nxt_val
);

    logic hit;

    always_comb begin
        hit     = cdb_valid && (cur_tag != '0) && (cur_tag == cdb_tag);
        nxt_tag = hit ? '0 : cur_tag;
        nxt_val = hit ? cdb_value : cur_val;
    end

endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pool_pkg::*;
#(
    parameter int NUM_RS   = 4,
    parameter int OP_W     = 4,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 16,
    parameter int TAG_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [IMM_W-1:0]  iss_imm,
    input  logic [TAG_W-1:0]  iss_src1_tag,
    input  logic [DATA_W-1:0] iss_src1_val,
    input  logic [TAG_W-1:0]  iss_src2_tag,
    input  logic [DATA_W-1:0] iss_src2_val,
    output logic              iss_stall,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              fu_valid,
    output logic [TAG_W-1:0]  fu_tag,
    output logic [OP_W-1:0]   fu_op,
    output logic [DATA_W-1:0] fu_a,
    output logic [DATA_W-1:0] fu_b,
    output logic [IMM_W-1:0]  fu_imm
);

    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

    typedef struct packed {
        rs_state_e         st;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  qj;
        logic [TAG_W-1:0]  qk;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
        logic [IMM_W-1:0]  a;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_RS-1:0] ent;
    } pool_t;

    pool_t state_d, state_q;

    logic [NUM_RS-1:0] busy_vec;
    logic [NUM_RS-1:0] ready_vec;

    logic [TAG_W-1:0]  cap_qj [NUM_RS];
    logic [TAG_W-1:0]  cap_qk [NUM_RS];
    logic [DATA_W-1:0] cap_vj [NUM_RS];
    logic [DATA_W-1:0] cap_vk [NUM_RS];

    logic [TAG_W-1:0]  byp_q1, byp_q2;
    logic [DATA_W-1:0] byp_v1, byp_v2;

    logic             alloc_found, disp_found;
    logic [IDX_W-1:0] alloc_idx, disp_idx;

    // Per-station operand snooping and status
    for (genvar g = 0; g < NUM_RS; g++) begin : g_st
        rs_operand_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_cap_j (
            .cur_tag   (state_q.ent[g].qj),
            .cur_val   (state_q.ent[g].vj),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_value (cdb_value),
            .nxt_tag   (cap_qj[g]),
            .nxt_val   (cap_vj[g])
        );
        rs_operand_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_cap_k (
            .cur_tag   (state_q.ent[g].qk),
            .cur_val   (state_q.ent[g].vk),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_value (cdb_value),
            .nxt_tag   (cap_qk[g]),
            .nxt_val   (cap_vk[g])
        );
        assign busy_vec[g]  = (state_q.ent[g].st != ST_FREE);
        assign ready_vec[g] = (state_q.ent[g].st == ST_WAIT)
                              && (state_q.ent[g].qj == '0)
                              && (state_q.ent[g].qk == '0);
    end

    // Same-cycle wakeup of the sources being issued
    rs_operand_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_byp_1 (
        .cur_tag   (iss_src1_tag),
        .cur_val   (iss_src1_val),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_value (cdb_value),
        .nxt_tag   (byp_q1),
        .nxt_val   (byp_v1)
    );
    rs_operand_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_byp_2 (
        .cur_tag   (iss_src2_tag),
        .cur_val   (iss_src2_val),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_value (cdb_value),
        .nxt_tag   (byp_q2),
        .nxt_val   (byp_v2)
    );

    rs_lowest_pick #(.N(NUM_RS)) u_alloc (
        .req   (~busy_vec),
        .found (alloc_found),
        .idx   (alloc_idx)
    );

    rs_lowest_pick #(.N(NUM_RS)) u_disp (
        .req   (ready_vec),
        .found (disp_found),
        .idx   (disp_idx)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_RS; i++) begin
            state_d.ent[i].qj = cap_qj[i];
            state_d.ent[i].vj = cap_vj[i];
            state_d.ent[i].qk = cap_qk[i];
            state_d.ent[i].vk = cap_vk[i];
            if (disp_found && (disp_idx == IDX_W'(i))) begin
                state_d.ent[i].st = ST_EXEC;
            end
            if (cdb_valid && (cdb_tag == TAG_W'(TAG_BASE + i))) begin
                state_d.ent[i].st = ST_FREE;
            end
        end
        if (iss_valid && alloc_found) begin
            state_d.ent[alloc_idx].st = ST_WAIT;
            state_d.ent[alloc_idx].op = iss_op;
            state_d.ent[alloc_idx].a  = iss_imm;
            state_d.ent[alloc_idx].qj = byp_q1;
            state_d.ent[alloc_idx].vj = byp_v1;
            state_d.ent[alloc_idx].qk = byp_q2;
            state_d.ent[alloc_idx].vk = byp_v2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    assign iss_stall = !alloc_found;
    assign iss_tag   = TAG_W'(TAG_BASE) + TAG_W'(alloc_idx);
    assign fu_valid  = disp_found;
    assign fu_tag    = TAG_W'(TAG_BASE) + TAG_W'(disp_idx);
    assign fu_op     = state_q.ent[disp_idx].op;
    assign fu_a      = state_q.ent[disp_idx].vj;
    assign fu_b      = state_q.ent[disp_idx].vk;
    assign fu_imm    = state_q.ent[disp_idx].a;

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
    parameter int NUM_RS   = 4,
    parameter int TAG_W    = 4,
    parameter int TAG_BASE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic              iss_stall,
    input logic [TAG_W-1:0]  iss_tag,
    input logic              cdb_valid,
    input logic [TAG_W-1:0]  cdb_tag,
    input logic              fu_valid,
    input logic [TAG_W-1:0]  fu_tag,
    input logic [NUM_RS-1:0] busy_vec,
    input logic [NUM_RS-1:0] ready_vec
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!fu_valid && !iss_stall));

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_stall && !cdb_valid) |=> iss_stall);

    p_dispatch_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fu_valid |=> !(fu_valid && (fu_tag == $past(fu_tag))));

    for (genvar g = 0; g < NUM_RS; g++) begin : g_chk
        p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && !iss_stall && (iss_tag == TAG_W'(TAG_BASE + g)))
            |=> busy_vec[g]);

        p_free_on_bcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cdb_valid && busy_vec[g] && (cdb_tag == TAG_W'(TAG_BASE + g)))
            |=> !busy_vec[g]);

        p_lowest_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ready_vec[g] |-> (fu_valid && (fu_tag <= TAG_W'(TAG_BASE + g))));
    end

endmodule

bind rs_pool rs_pool_chk #(
    .NUM_RS   (NUM_RS),
    .TAG_W    (TAG_W),
    .TAG_BASE (TAG_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_stall (iss_stall),
    .iss_tag   (iss_tag),
    .cdb_valid (cdb_valid),
    .cdb_tag   (cdb_tag),
    .fu_valid  (fu_valid),
    .fu_tag    (fu_tag),
    .busy_vec  (busy_vec),
    .ready_vec (ready_vec)
);

// File: tb/rs_pool_tb.sv
module rs_pool_tb;

    localparam int OP_W = 4, TAG_W = 4, DATA_W = 32, IMM_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              iss_valid, iss_stall, cdb_valid, fu_valid;
    logic [OP_W-1:0]   iss_op, fu_op;
    logic [IMM_W-1:0]  iss_imm, fu_imm;
    logic [TAG_W-1:0]  iss_src1_tag, iss_src2_tag, iss_tag, cdb_tag, fu_tag;
    logic [DATA_W-1:0] iss_src1_val, iss_src2_val, cdb_value, fu_a, fu_b;

    rs_pool u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_imm(iss_imm),
        .iss_src1_tag(iss_src1_tag), .iss_src1_val(iss_src1_val),
        .iss_src2_tag(iss_src2_tag), .iss_src2_val(iss_src2_val),
        .iss_stall(iss_stall), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .fu_valid(fu_valid), .fu_tag(fu_tag), .fu_op(fu_op),
        .fu_a(fu_a), .fu_b(fu_b), .fu_imm(fu_imm)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] imm;
        logic [3:0]  t1;
        logic [31:0] v1;
        logic [3:0]  t2;
        logic [31:0] v2;
        logic        cv;
        logic [3:0]  ct;
        logic [31:0] cval;
        logic [31:0] ea;
        logic [31:0] eb;
    } vec_t;

    // Single instruction into an empty pool, optional same-cycle broadcast
    localparam vec_t VECS [5] = '{
        '{4'h3, 16'h0100, 4'h0, 32'h0000_0011, 4'h0, 32'h0000_0022, 1'b0, 4'h0, 32'h0,         32'h0000_0011, 32'h0000_0022},
        '{4'h5, 16'h0abc, 4'h7, 32'h0000_dead, 4'h0, 32'h0000_0033, 1'b1, 4'h7, 32'h0000_aaaa, 32'h0000_aaaa, 32'h0000_0033},
        '{4'h9, 16'hffff, 4'h0, 32'h0000_0044, 4'h9, 32'h0000_0000, 1'b1, 4'h9, 32'h0000_bbbb, 32'h0000_0044, 32'h0000_bbbb},
        '{4'h2, 16'h1234, 4'h6, 32'h0000_0000, 4'h6, 32'h0000_0001, 1'b1, 4'h6, 32'h0000_00cc, 32'h0000_00cc, 32'h0000_00cc},
        '{4'hf, 16'h0000, 4'h0, 32'hffff_ffff, 4'h0, 32'h0000_0000, 1'b1, 4'h8, 32'h1111_1111, 32'hffff_ffff, 32'h0000_0000}
    };

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 1'b0; iss_op = '0; iss_imm = '0;
        iss_src1_tag = '0; iss_src1_val = '0;
        iss_src2_tag = '0; iss_src2_val = '0;
        cdb_valid = 1'b0; cdb_tag = '0; cdb_value = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [3:0] op, input logic [15:0] imm,
                         input logic [3:0] t1, input logic [31:0] v1,
                         input logic [3:0] t2, input logic [31:0] v2);
        iss_valid = 1'b1; iss_op = op; iss_imm = imm;
        iss_src1_tag = t1; iss_src1_val = v1;
        iss_src2_tag = t2; iss_src2_val = v2;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 stall after reset", iss_stall, 0);
        chk("R1 fu_valid after reset", fu_valid, 0);
        chk("R1 first tag", iss_tag, 1);

        // Vector table: R4, R6, R7, R8, R10
        for (int n = 0; n < 5; n++) begin
            issue(VECS[n].op, VECS[n].imm, VECS[n].t1, VECS[n].v1, VECS[n].t2, VECS[n].v2);
            cdb_valid = VECS[n].cv; cdb_tag = VECS[n].ct; cdb_value = VECS[n].cval;
            chk("R2 tag of empty pool", iss_tag, 1);
            step();
            idle();
            chk("R7 offered after capture", fu_valid, 1);
            chk("R7 offered tag", fu_tag, 1);
            chk("R7 opcode", fu_op, VECS[n].op);
            chk("R4 R6 operand a", fu_a, VECS[n].ea);
            chk("R4 R6 operand b", fu_b, VECS[n].eb);
            chk("R10 immediate", fu_imm, VECS[n].imm);
            step();
            chk("R8 offered once", fu_valid, 0);
            cdb_valid = 1'b1; cdb_tag = 4'd1; cdb_value = 32'h0;
            step();
            idle();
            chk("R9 station released", iss_stall, 0);
        end

        // R2/R3: fill the pool with instructions waiting on external tag 10
        for (int s = 0; s < 4; s++) begin
            issue(4'(s), 16'(s), 4'd10, 32'h0, 4'd0, 32'd100 + 32'(s));
            chk("R2 lowest free tag", iss_tag, 64'(1 + s));
            chk("R3 no stall while free", iss_stall, 0);
            step();
        end
        idle();
        chk("R3 stall when full", iss_stall, 1);
        chk("R4 nonzero tag waits", fu_valid, 0);

        // R3: instruction offered during stall must be dropped
        issue(4'he, 16'h7777, 4'd0, 32'h77, 4'd0, 32'h77);
        step();
        idle();
        chk("R3 stall persists", iss_stall, 1);

        // R5: one broadcast wakes all four; R8: dispatched 1..4 one per cycle
        cdb_valid = 1'b1; cdb_tag = 4'd10; cdb_value = 32'h0000_c0de;
        step();
        idle();
        for (int s = 0; s < 4; s++) begin
            chk("R5 woken station offered", fu_valid, 1);
            chk("R8 dispatch order", fu_tag, 64'(1 + s));
            chk("R5 captured value", fu_a, 32'h0000_c0de);
            chk("R5 ready value kept", fu_b, 32'd100 + 32'(s));
            chk("R9 stall held while executing", iss_stall, 1);
            step();
        end
        chk("R3 dropped instruction absent", fu_valid, 0);

        // R9: release station 3; stall still high in broadcast cycle
        cdb_valid = 1'b1; cdb_tag = 4'd3; cdb_value = 32'h0;
        chk("R9 stall in broadcast cycle", iss_stall, 1);
        step();
        idle();
        chk("R9 stall released", iss_stall, 0);
        chk("R9 released slot", iss_tag, 3);

        // R7: dependent instruction waits for station 2's result
        issue(4'h6, 16'h0042, 4'd2, 32'h0, 4'd0, 32'h99);
        step();
        idle();
        chk("R7 waits for operand", fu_valid, 0);
        chk("R3 full again", iss_stall, 1);
        cdb_valid = 1'b1; cdb_tag = 4'd2; cdb_value = 32'h0000_5555;
        step();
        idle();
        chk("R7 offered after wakeup", fu_valid, 1);
        chk("R7 dependent tag", fu_tag, 3);
        chk("R5 dependent operand", fu_a, 32'h0000_5555);
        chk("R7 ready operand", fu_b, 32'h99);
        chk("R10 dependent immediate", fu_imm, 16'h0042);
        chk("R9 producer station freed", iss_tag, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule